// File: doc/BRIEF.md
# Grouped Priority Interrupt Resolver

This block holds the arbitration state for a bank of interrupt lines. Each line has an enable flag, a pending flag, an active flag and a 4-bit priority, where a smaller number is more urgent. Every cycle it names the single most urgent request that is both pending and enabled. It also reports whether that request may interrupt the work already in service.

A 3-bit grouping field splits every priority into a pre-emption part (the upper bits) and a subpriority part (the lower bits). Only the pre-emption part decides nesting. Selection among pending requests compares the pre-emption part, then the subpriority, then the line number. Because the pre-emption part sits above the subpriority, this is the same as comparing the whole 4-bit value and then the line number.

Software uses one-cycle strobes to set and clear enables and pending flags, to load priorities and to write the grouping field. The consumer raises `accept` to take the winner and `done` to retire an active line.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, all enable, pending and active bits, all priorities and the grouping field are zero, and `win_valid` and `take_ok` are low.
- R2: `en_set`/`en_clr` set and clear enable bits. `pend_set` or `irq_req` set pending bits and `pend_clr` clears them. A set and a clear of the same pending bit in the same cycle leave it set. Each change is visible the cycle after the strobe.
- R3: Only lines that are both pending and enabled compete. A disabled line keeps its pending bit, and `win_valid` is low when no line competes.
- R4: The winner has the lowest 4-bit priority value. Among equal values, the lowest line number wins.
- R5: `ctrl_we` loads the grouping field from `ctrl_wdata[10:8]`. Pre-emption/sub bit splits are: values 0 to 3 give 4/0, 4 gives 3/1, 5 gives 2/2, 6 gives 1/3 and 7 gives 0/4.
- R6: `take_ok` is high when a winner exists and either no line is active, or the winner's pre-emption part is strictly lower than the lowest pre-emption part among active lines. An equal value waits.
- R7: With grouping 7 (0/4) and any line active, `take_ok` stays low.
- R8: `accept` while `take_ok` is high clears the winner's pending bit and sets its active bit on the next cycle. `accept` while `take_ok` is low has no effect.
- R9: `done` with `done_idx` clears that line's active bit on the next cycle.
- R10: `prio_we` loads `prio_wdata` into the priority of line `prio_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_IRQ | Request lines, each sets its pending bit |
| en_set | input | N_IRQ | Enable set strobes |
| en_clr | input | N_IRQ | Enable clear strobes |
| pend_set | input | N_IRQ | Pending set strobes |
| pend_clr | input | N_IRQ | Pending clear strobes |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | ID_W | Line whose priority is written |
| prio_wdata | input | PRIO_W | Priority value |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word, grouping in [10:8] |
| accept | input | 1 | Take the current winner |
| done | input | 1 | Retire an active line |
| done_idx | input | ID_W | Line to retire |
| enable | output | N_IRQ | Enable bits |
| pending | output | N_IRQ | Pending bits |
| active | output | N_IRQ | Active bits |
| grouping | output | 3 | Grouping field |
| win_valid | output | 1 | A competing line exists |
| win_id | output | ID_W | Winning line number |
| take_ok | output | 1 | Winner may pre-empt the running level |

## Verification
Selection is tried with disabled-but-pending lines, which separates arbitration from the pending state. Two lines sharing a priority check the tie break by line number, and a more urgent late arrival checks value ordering. Pre-emption is tried by keeping the same active line and changing only the grouping (2/2, 0/4, 4/0), so the equal, strictly-lower and no-nesting cases each flip `take_ok`. Accept while blocked, retiring in both orders, and simultaneous set/clear strobes check that bookkeeping follows only the defined events.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 4,
  parameter int ID_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  en_set,
  input  logic [N_IRQ-1:0]  en_clr,
  input  logic [N_IRQ-1:0]  pend_set,
  input  logic [N_IRQ-1:0]  pend_clr,
  input  logic              prio_we,
  input  logic [ID_W-1:0]   prio_idx,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  input  logic              accept,
  input  logic              done,
  input  logic [ID_W-1:0]   done_idx,
  output logic [N_IRQ-1:0]  enable,
  output logic [N_IRQ-1:0]  pending,
  output logic [N_IRQ-1:0]  active,
  output logic [2:0]        grouping,
  output logic              win_valid,
  output logic [ID_W-1:0]   win_id,
  output logic              take_ok
);

  localparam int GRP_LSB = 8;

  logic [PRIO_W-1:0] prio [N_IRQ];
  logic [N_IRQ-1:0]  cand;
  logic [PRIO_W-1:0] best;
  logic [2:0]        sub_bits;
  logic [PRIO_W-1:0] run_pre;
  logic              act_any;
  logic [N_IRQ-1:0]  acc_mask;
  logic [N_IRQ-1:0]  done_mask;

  assign cand     = pending & enable;
  assign sub_bits = (grouping > 3'd3) ? grouping - 3'd3 : 3'd0;
  assign act_any  = |active;

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    best      = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && (!win_valid || prio[i] < best)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        best      = prio[i];
      end
    end
  end

  always_comb begin
    run_pre = '1;
    for (int i = 0; i < N_IRQ; i++)
      if (active[i] && (prio[i] >> sub_bits) < run_pre)
        run_pre = prio[i] >> sub_bits;
  end

  assign take_ok   = win_valid && (!act_any || (best >> sub_bits) < run_pre);
  assign acc_mask  = (accept && take_ok) ? (N_IRQ'(1) << win_id) : '0;
  assign done_mask = done ? (N_IRQ'(1) << done_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= '0;
      pending  <= '0;
      active   <= '0;
      grouping <= '0;
      for (int i = 0; i < N_IRQ; i++) prio[i] <= '0;
    end else begin
      enable  <= (enable & ~en_clr) | en_set;
      pending <= (pending & ~pend_clr & ~acc_mask) | pend_set | irq_req;
      active  <= (active & ~done_mask) | acc_mask;
      if (ctrl_we) grouping <= ctrl_wdata[GRP_LSB+2:GRP_LSB];
      if (prio_we) prio[prio_idx] <= prio_wdata;
    end
  end

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int N_IRQ = 8,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] enable,
  input logic [N_IRQ-1:0] pending,
  input logic [N_IRQ-1:0] active,
  input logic [2:0]       grouping,
  input logic             win_valid,
  input logic [ID_W-1:0]  win_id,
  input logic             take_ok,
  input logic             accept,
  input logic             done,
  input logic [ID_W-1:0]  done_idx
);

  p_win_is_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (enable[win_id] && pending[win_id]));

  p_no_cand_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> ((enable & pending) == '0));

  p_take_needs_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |-> win_valid);

  p_flat_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grouping == 3'd7 && active != '0) |-> !take_ok);

  p_accept_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && take_ok) |=> active[$past(win_id)]);

  p_accept_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !take_ok && !done) |=> $stable(active));

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(accept && take_ok)) |=> !active[$past(done_idx)]);

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pending(pending), .active(active),
  .grouping(grouping), .win_valid(win_valid), .win_id(win_id), .take_ok(take_ok),
  .accept(accept), .done(done), .done_idx(done_idx)
);

// File: tb/tb_irq_prio_resolver.sv
module tb_irq_prio_resolver;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, en_set = '0, en_clr = '0, pend_set = '0, pend_clr = '0;
  logic prio_we = 0, ctrl_we = 0, accept = 0, done = 0;
  logic [IW-1:0] prio_idx = '0, done_idx = '0;
  logic [3:0] prio_wdata = '0;
  logic [31:0] ctrl_wdata = '0;
  logic [N-1:0] enable, pending, active;
  logic [2:0] grouping;
  logic win_valid, take_ok;
  logic [IW-1:0] win_id;

  irq_prio_resolver #(.N_IRQ(N), .PRIO_W(4)) dut (.*);

  always #2 clk = ~clk;

  typedef enum int {K_WV, K_WID, K_TAKE, K_PEND, K_ACT, K_EN, K_GRP} kind_e;
  typedef struct { string req; kind_e kind; int exp; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        K_WV:   act = int'(win_valid);
        K_WID:  act = int'(win_id);
        K_TAKE: act = int'(take_ok);
        K_PEND: act = int'(pending);
        K_ACT:  act = int'(active);
        K_EN:   act = int'(enable);
        default: act = int'(grouping);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual 0x%0h expected 0x%0h", it.req, it.kind.name(), act, it.exp);
      end
    end
  end

  task automatic expect_v(string req, kind_e k, int v);
    item_t it;
    it.req = req; it.kind = k; it.exp = v;
    q.push_back(it);
  endtask

  task automatic finish_pulse();
    @(posedge clk); #1;
    irq_req = '0; en_set = '0; en_clr = '0; pend_set = '0; pend_clr = '0;
    prio_we = 0; ctrl_we = 0; accept = 0; done = 0;
  endtask

  task automatic w_prio(int idx, int v);
    @(negedge clk); prio_we = 1; prio_idx = IW'(idx); prio_wdata = 4'(v); finish_pulse();
  endtask
  task automatic w_grp(logic [31:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = w; finish_pulse();
  endtask
  task automatic s_pend(logic [N-1:0] s, logic [N-1:0] c);
    @(negedge clk); pend_set = s; pend_clr = c; finish_pulse();
  endtask
  task automatic s_en(logic [N-1:0] s, logic [N-1:0] c);
    @(negedge clk); en_set = s; en_clr = c; finish_pulse();
  endtask
  task automatic s_irq(logic [N-1:0] m);
    @(negedge clk); irq_req = m; finish_pulse();
  endtask
  task automatic s_acc();
    @(negedge clk); accept = 1; finish_pulse();
  endtask
  task automatic s_done(int idx);
    @(negedge clk); done = 1; done_idx = IW'(idx); finish_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_v("R1", K_EN, 0); expect_v("R1", K_PEND, 0); expect_v("R1", K_ACT, 0);
    expect_v("R1", K_GRP, 0); expect_v("R1", K_WV, 0); expect_v("R1", K_TAKE, 0);

    w_prio(1, 9); w_prio(2, 5); w_prio(5, 5); w_prio(6, 2);  // R10
    s_pend(8'b0010_0110, '0);
    expect_v("R3", K_PEND, 8'b0010_0110); expect_v("R3", K_WV, 0);
    s_en(8'b0010_0110, '0);
    expect_v("R2", K_EN, 8'b0010_0110);
    expect_v("R4", K_WV, 1); expect_v("R4", K_WID, 2); expect_v("R6", K_TAKE, 1);

    w_grp(32'h0000_0500);
    expect_v("R5", K_GRP, 5);
    s_acc();
    expect_v("R8", K_ACT, 8'b0000_0100); expect_v("R8", K_PEND, 8'b0010_0010);
    expect_v("R10", K_WID, 5); expect_v("R6", K_TAKE, 0);
    s_acc();
    expect_v("R8", K_ACT, 8'b0000_0100); expect_v("R8", K_PEND, 8'b0010_0010);

    s_pend(8'b0100_0000, '0); s_en(8'b0100_0000, '0);
    expect_v("R4", K_WID, 6); expect_v("R6", K_TAKE, 1);
    w_grp(32'h0000_0700);
    expect_v("R7", K_WID, 6); expect_v("R7", K_TAKE, 0);
    w_grp(32'h0000_0300);
    expect_v("R5", K_GRP, 3); expect_v("R6", K_TAKE, 1);

    s_acc();
    expect_v("R8", K_ACT, 8'b0100_0100); expect_v("R8", K_PEND, 8'b0010_0010);
    expect_v("R4", K_WID, 5); expect_v("R6", K_TAKE, 0);
    s_done(6);
    expect_v("R9", K_ACT, 8'b0000_0100); expect_v("R6", K_TAKE, 0);
    s_done(2);
    expect_v("R9", K_ACT, 0); expect_v("R6", K_TAKE, 1);

    s_pend('0, 8'b0010_0000);
    expect_v("R2", K_PEND, 8'b0000_0010); expect_v("R4", K_WID, 1);
    s_en('0, 8'b0000_0010);
    expect_v("R3", K_WV, 0); expect_v("R3", K_PEND, 8'b0000_0010);
    s_pend(8'b0000_1000, 8'b0000_1000);
    expect_v("R2", K_PEND, 8'b0000_1010);
    s_irq(8'b1000_0000);
    expect_v("R2", K_PEND, 8'b1000_1010);
    w_grp(32'hFFFF_F9FF);
    expect_v("R5", K_GRP, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule